// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block governs a deep-sleep state of a small controller. In this state the main crystal oscillator is switched off and only a free-running RC clock keeps the watchdog alive. The CPU asks for the state with a stop request. The request takes effect only when the two mode-select bits are set to the one valid code. While the block is halted, either an external interrupt or a qualified watchdog event ends the sleep.

A wake-up does not hand the clock back at once. The block first restarts the oscillator. It then lets a cleared 8-bit interval counter run from 00h up through FFh. That counter is stepped by a prescaler whose ratio is captured when the stop is entered. The software picks the ratio so that the interval is longer than the oscillator start-up time, typically more than 20 ms. When the counter wraps, the CPU clock is enabled again. One cycle later the block gives a single pulse that says how execution continues: an interrupt vector, an internal reset, or a plain resume after the stop instruction.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level or pulse control signal. A hardware reset takes the block straight back to the running state. Its captured settings do not survive the reset. A wake by interrupt leaves the configuration held outside the block untouched.

Top module: `stop_wake_seq`

## Requirements
- R1: A stop is entered only when `stop_req` is high in the running state while `mode_wake`=0 and `mode_rcwd`=1. The other three codes (00, 10, 11) leave `osc_en` and `cpu_clk_en` high.
- R2: From the cycle after entry until a wake event is accepted, `osc_en` and `cpu_clk_en` are both low.
- R3: While halted, `ext_irq` always wakes the block. `wdt_evt` wakes it only when `wdt_rst_mode`=1 or `wdt_irq_en`=1. Otherwise the watchdog event is ignored and the block stays halted.
- R4: After a wake event is sampled, `osc_en` is high and `cpu_clk_en` is low for exactly 256 × 2^`div_sel` clock edges. `div_sel` (0..7) is the value captured on stop entry; later changes to it have no effect.
- R5: When the interval ends, `cpu_clk_en` rises together with a single one-cycle completion pulse. The block then returns to the running state.
- R6: If `irq_en`=1 at the wake and the cause is not a watchdog reset, `vec_req` pulses. `vec_wdt` is 1 for a watchdog interrupt wake and 0 for an external interrupt wake.
- R7: A watchdog event with `wdt_rst_mode`=1 yields an `int_rst_req` pulse and nothing else, whatever `irq_en` is. If it arrives in the same cycle as `ext_irq`, it wins over `ext_irq`.
- R8: If `irq_en`=0 at the wake and the cause is not a watchdog reset, only `resume` pulses.
- R9: Asserting `rst_n` low in any state drives `osc_en` and `cpu_clk_en` high at once and produces no completion pulse.
- R10: A stop request made during the stabilization interval, or in the completion cycle, is ignored. The block goes back to running and does not halt.
- R11: At most one of `vec_req`, `int_rst_req` and `resume` is high in any cycle, and each is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, running from the RC source during stop |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| stop_req | input | 1 | Stop instruction executed by the CPU |
| mode_wake | input | 1 | Mode-select bit, must be 0 to enter |
| mode_rcwd | input | 1 | Mode-select bit, must be 1 to enter |
| div_sel | input | 3 | Prescaler ratio 2^div_sel, captured on entry |
| ext_irq | input | 1 | External interrupt wake event |
| wdt_evt | input | 1 | Watchdog timeout event |
| irq_en | input | 1 | Global interrupt-enable flag |
| wdt_rst_mode | input | 1 | Watchdog acts as reset when 1 |
| wdt_irq_en | input | 1 | Watchdog interrupt enabled when 1 |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| vec_req | output | 1 | One-cycle interrupt vector request |
| vec_wdt | output | 1 | Vector is the watchdog one (valid with vec_req) |
| int_rst_req | output | 1 | One-cycle internal reset request |
| resume | output | 1 | One-cycle resume-after-stop strobe |

## Verification
A wrong prescaler capture or a bad counter clear shows up only at the end of the wake sequence. It appears as a `cpu_clk_en` rise that is early or late by whole prescaler periods, so every wake is checked against the exact expected edge count. A wrong wake cause or a badly sampled `irq_en` shows up in the same completion cycle as the wrong pulse, or as the wrong `vec_wdt` value. A state machine that takes an event it should ignore shows at once: `osc_en` rises while halted, or falls while the block is settling.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    SW_RUN    = 2'd0,
    SW_HALT   = 2'd1,
    SW_SETTLE = 2'd2,
    SW_DONE   = 2'd3
  } swk_state_e;

  typedef enum logic [1:0] {
    WK_EXT  = 2'd0,
    WK_WIRQ = 2'd1,
    WK_WRST = 2'd2
  } swk_cause_e;
endpackage

// File: rtl/swk_prescaler.sv
module swk_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW = (1 << SEL_W) - 1;

  logic [PW-1:0] cnt;
  logic [PW:0]   full;
  logic [PW:0]   lim;

  // the tick falls once every 2^sel enabled cycles
  assign full = (PW+1)'(1) << sel;
  assign lim  = full - 1'b1;
  assign tick = en && (cnt == lim[PW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (en)     cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/swk_stab_counter.sv
module swk_stab_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic ovf
);
  logic [CNT_W-1:0] cnt;

  assign ovf = step && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swk_wake_decide.sv
module swk_wake_decide
  import swk_pkg::*;
(
  input  logic       ext_irq,
  input  logic       wdt_evt,
  input  logic       wdt_rst_mode,
  input  logic       wdt_irq_en,
  output logic       wake,
  output swk_cause_e cause
);
  always_comb begin
    wake  = 1'b0;
    cause = WK_EXT;
    if (wdt_evt && wdt_rst_mode) begin
      wake  = 1'b1;
      cause = WK_WRST;
    end else if (ext_irq) begin
      wake  = 1'b1;
      cause = WK_EXT;
    end else if (wdt_evt && wdt_irq_en) begin
      wake  = 1'b1;
      cause = WK_WIRQ;
    end
  end
endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq
  import swk_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             mode_wake,
  input  logic             mode_rcwd,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             ext_irq,
  input  logic             wdt_evt,
  input  logic             irq_en,
  input  logic             wdt_rst_mode,
  input  logic             wdt_irq_en,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             vec_req,
  output logic             vec_wdt,
  output logic             int_rst_req,
  output logic             resume
);
  swk_state_e       state, state_nx;
  swk_cause_e       cause_q, cause_w;
  logic [SEL_W-1:0] sel_q;
  logic             ien_q;
  logic             wake_w, tick, ovf, enter_ok;

  assign enter_ok = stop_req && !mode_wake && mode_rcwd;

  swk_wake_decide u_decide (
    .ext_irq      (ext_irq),
    .wdt_evt      (wdt_evt),
    .wdt_rst_mode (wdt_rst_mode),
    .wdt_irq_en   (wdt_irq_en),
    .wake         (wake_w),
    .cause        (cause_w)
  );

  swk_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state == SW_HALT),
    .en    (state == SW_SETTLE),
    .sel   (sel_q),
    .tick  (tick)
  );

  swk_stab_counter #(.CNT_W(CNT_W)) u_stab (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state == SW_HALT),
    .step  (tick),
    .ovf   (ovf)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      SW_RUN:    if (enter_ok) state_nx = SW_HALT;
      SW_HALT:   if (wake_w)   state_nx = SW_SETTLE;
      SW_SETTLE: if (ovf)      state_nx = SW_DONE;
      SW_DONE:                 state_nx = SW_RUN;
      default:                 state_nx = SW_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SW_RUN;
      sel_q   <= '0;
      cause_q <= WK_EXT;
      ien_q   <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == SW_RUN && enter_ok) sel_q <= div_sel;
      if (state == SW_HALT && wake_w) begin
        cause_q <= cause_w;
        ien_q   <= irq_en;
      end
    end
  end

  assign osc_en      = (state != SW_HALT);
  assign cpu_clk_en  = (state == SW_RUN) || (state == SW_DONE);
  assign int_rst_req = (state == SW_DONE) && (cause_q == WK_WRST);
  assign vec_req     = (state == SW_DONE) && (cause_q != WK_WRST) && ien_q;
  assign vec_wdt     = vec_req && (cause_q == WK_WIRQ);
  assign resume      = (state == SW_DONE) && (cause_q != WK_WRST) && !ien_q;
endmodule

// File: rtl/stop_wake_seq_chk.sv
module stop_wake_seq_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             mode_wake,
  input logic             mode_rcwd,
  input logic [SEL_W-1:0] div_sel,
  input logic             ext_irq,
  input logic             wdt_evt,
  input logic             irq_en,
  input logic             wdt_rst_mode,
  input logic             wdt_irq_en,
  input logic             osc_en,
  input logic             cpu_clk_en,
  input logic             vec_req,
  input logic             vec_wdt,
  input logic             int_rst_req,
  input logic             resume
);
  logic any_pulse;
  assign any_pulse = vec_req || int_rst_req || resume;

  // R1
  bad_code_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && cpu_clk_en && !(stop_req && !mode_wake && mode_rcwd)) |=> osc_en);

  // R2
  halt_clock_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> !cpu_clk_en);

  // R3
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !ext_irq && !(wdt_evt && (wdt_rst_mode || wdt_irq_en))) |=> !osc_en);

  // R5
  pulse_with_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> (cpu_clk_en && osc_en));

  // R6
  vec_wdt_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_wdt |-> vec_req);

  // R10
  settle_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en && !cpu_clk_en) |=> osc_en);

  // R11
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vec_req, int_rst_req, resume}));

  // R11
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |=> !any_pulse);
endmodule

bind stop_wake_seq stop_wake_seq_chk #(.SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_stop_wake_seq.sv
module test_stop_wake_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0, mode_wake = 1'b0, mode_rcwd = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic       ext_irq = 1'b0, wdt_evt = 1'b0, irq_en = 1'b0;
  logic       wdt_rst_mode = 1'b0, wdt_irq_en = 1'b0;
  logic       osc_en, cpu_clk_en, vec_req, vec_wdt, int_rst_req, resume;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // kinds: 0 vector ext, 1 vector watchdog, 2 internal reset, 3 resume
  int exp_kind[$];
  int exp_cyc[$];
  string exp_req[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stop_wake_seq i_stop_wake_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mode_wake(mode_wake),
    .mode_rcwd(mode_rcwd), .div_sel(div_sel), .ext_irq(ext_irq),
    .wdt_evt(wdt_evt), .irq_en(irq_en), .wdt_rst_mode(wdt_rst_mode),
    .wdt_irq_en(wdt_irq_en), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .vec_req(vec_req), .vec_wdt(vec_wdt), .int_rst_req(int_rst_req),
    .resume(resume)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a completion pulse appears
  always @(negedge clk) begin
    if (rst_n && (vec_req || int_rst_req || resume)) begin
      int k;
      k = vec_req ? (vec_wdt ? 1 : 0) : (int_rst_req ? 2 : 3);
      if (exp_kind.size() == 0) begin
        check(1'b0, "R11 unexpected pulse", k, -1);
      end else begin
        int ek, ec;
        string r;
        ek = exp_kind.pop_front();
        ec = exp_cyc.pop_front();
        r  = exp_req.pop_front();
        check(k == ek, r, k, ek);
        check(cyc == ec, "R4 interval length", cyc, ec);
        check(cpu_clk_en == 1'b1, "R5 clock back with pulse", cpu_clk_en, 1);
        check($countones({vec_req, int_rst_req, resume}) == 1, "R11 one pulse",
              $countones({vec_req, int_rst_req, resume}), 1);
      end
    end
  end

  task automatic enter_stop(input logic [2:0] sel);
    @(negedge clk);
    div_sel = sel; mode_wake = 1'b0; mode_rcwd = 1'b1; stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check(osc_en == 1'b0, "R2 osc off in stop", osc_en, 0);
    check(cpu_clk_en == 1'b0, "R2 cpu clock off in stop", cpu_clk_en, 0);
  endtask

  // driver: applies a wake event and pushes the expected completion
  task automatic wake(input bit e, input bit w, input int kind, input int ratio, input string req);
    @(negedge clk);
    ext_irq = e; wdt_evt = w;
    exp_kind.push_back(kind);
    exp_cyc.push_back(cyc + 1 + 256 * ratio);
    exp_req.push_back(req);
    @(negedge clk);
    ext_irq = 1'b0; wdt_evt = 1'b0;
    check(osc_en == 1'b1 && cpu_clk_en == 1'b0, "R4 settling levels",
          {osc_en, cpu_clk_en}, 2);
  endtask

  task automatic wait_drain();
    int n = 0;
    while (exp_kind.size() != 0 && n < 40000) begin
      @(negedge clk);
      n++;
    end
    check(exp_kind.size() == 0, "R5 completion seen", exp_kind.size(), 0);
    @(negedge clk);
    check(osc_en && cpu_clk_en, "R5 back to run", {osc_en, cpu_clk_en}, 3);
  endtask

  initial begin
    #1 ;
    check(osc_en == 1'b1 && cpu_clk_en == 1'b1, "R9 reset state", {osc_en, cpu_clk_en}, 3);
    check(!vec_req && !int_rst_req && !resume, "R9 no pulse in reset",
          {vec_req, int_rst_req, resume}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: the three wrong mode codes keep running
    for (int c = 0; c < 4; c++) begin
      if (c != 1) begin
        @(negedge clk);
        mode_wake = c[1]; mode_rcwd = c[0]; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check(osc_en && cpu_clk_en, "R1 wrong mode code ignored", {osc_en, cpu_clk_en}, 3);
      end
    end

    // R6: external wake, vector, ratio 1
    irq_en = 1'b1;
    enter_stop(3'd0);
    wake(1, 0, 0, 1, "R6 external vector");
    wait_drain();

    // R8: resume only, ratio 4
    irq_en = 1'b0;
    enter_stop(3'd2);
    wake(1, 0, 3, 4, "R8 resume strobe");
    wait_drain();

    // R3: unqualified watchdog ignored, then R6 watchdog interrupt vector
    irq_en = 1'b1; wdt_rst_mode = 1'b0; wdt_irq_en = 1'b0;
    enter_stop(3'd0);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk); wdt_evt = 1'b0;
    repeat (3) @(negedge clk);
    check(osc_en == 1'b0, "R3 unqualified watchdog ignored", osc_en, 0);
    wdt_irq_en = 1'b1;
    wake(0, 1, 1, 1, "R6 watchdog vector");
    wait_drain();

    // R7: watchdog reset beats external interrupt in the same cycle
    wdt_rst_mode = 1'b1;
    enter_stop(3'd0);
    wake(1, 1, 2, 1, "R7 internal reset");
    wait_drain();
    wdt_rst_mode = 1'b0; wdt_irq_en = 1'b0;

    // R4: ratio captured on entry (2), later change to 7 ignored; R10 stop in settle
    irq_en = 1'b1;
    enter_stop(3'd1);
    div_sel = 3'd7;
    wake(1, 0, 0, 2, "R4 captured ratio");
    repeat (10) @(negedge clk);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    check(osc_en == 1'b1, "R10 stop during settle ignored", osc_en, 0 + 1);
    wait_drain();
    repeat (3) @(negedge clk);
    check(osc_en && cpu_clk_en, "R10 no halt after settle", {osc_en, cpu_clk_en}, 3);

    // R9: hardware reset while halted
    enter_stop(3'd0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(osc_en && cpu_clk_en, "R9 reset leaves stop", {osc_en, cpu_clk_en}, 3);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    check(osc_en && cpu_clk_en, "R9 stays running", {osc_en, cpu_clk_en}, 3);

    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule